// File: doc/BRIEF.md
# Embedded Processor Timer Unit

This block supplies the three timers that an embedded processor core expects beside its pipeline. A free-running timebase advances once per `tb_tick`. The block derives from that timebase a periodic event, a reloadable down-counting interval timer and a two-stage watchdog. It is programmed through one control register and one status register on a simple write/read port.

The fixed-interval event and the watchdog period each fire on a 0-to-1 transition of one timebase bit. Each picks that bit with its own 2-bit period field. The tapped bit for field value `s` is `BASE + s*TAP_STEP`, with separate bases for the two timers. The watchdog walks through three stages on successive periods: arm, interrupt, reset. Software holds it back by clearing the two status bits that record its stage. At the final stage it records the selected reset kind and raises a one-cycle request towards the system reset logic, which lies outside this block.

The interval timer loads its counter at once when software writes a reload value, and it counts down on every tick while it is allowed to run. It can restart itself on expiry or stop there. Status flags clear when software writes a one to them, and each interrupt output is its status flag gated by the matching enable bit.

Top module: `emb_tmr_unit`

## Requirements
- R1: A control write stores only bits 31:22 of the data. Bits 21:0 read back as 0. Fields: 31:30 watchdog period select, 29:28 watchdog reset kind, 27 watchdog interrupt enable, 26 interval timer enable/interrupt enable, 25:24 fixed-interval period select, 23 fixed-interval interrupt enable, 22 interval auto-reload.
- R2: A status write clears each of status bits 31:26 written as 1 and leaves the others unchanged. Status bits 25:0 always read 0. Status bits: 31 watchdog armed, 30 watchdog interrupt, 29:28 last watchdog reset kind, 27 interval expired, 26 fixed-interval event.
- R3: On a tick that turns timebase bit `FIT_BASE + sel*TAP_STEP` (sel = control 25:24) from 0 to 1, status bit 26 is set. `irq_fit` equals status 26 AND control 23.
- R4: A write with `wr_sel`=2 loads the reload value and the counter in the same edge. A read with `rd_sel`=2 returns the live count, zero-extended. While running, the count drops by one per tick.
- R5: When a running counter at 1 or below takes a tick, status bit 27 is set. `irq_pit` equals status 27 AND control 26.
- R6: On expiry the counter reloads from the reload value if control bit 22 is set. Otherwise it goes to 0 and stays stopped until the next reload write.
- R7: The counter holds its value whenever the reload value is 1 or less, or control bit 26 is clear.
- R8: On a watchdog period (tap `WDT_BASE + sel*TAP_STEP`, sel = control 31:30) with status 31 clear, status 31 is set. With status 31:30 = 10, status 30 is set. `irq_wdt` equals status 30 AND control 27.
- R9: On a watchdog period with status 31:30 = 11, control 29:28 is copied into status 29:28. A one-cycle pulse follows on `rst_core_req` (kind 1), `rst_chip_req` (kind 2) or `rst_sys_req` (kind 3); kind 0 gives no pulse. At most one request is high at a time.
- R10: When a hardware event sets a status bit in the same edge as a status write clearing it, the bit ends set.
- R11: After reset the control, status, count and reload are 0 and every output is low.
- R12: The timebase advances by exactly one per `tb_tick`. A read with `rd_sel`=3 returns its low 32 bits. Writes with `wr_sel`=3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | Timebase advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 status, 2 interval reload, 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source: 0 control, 1 status, 2 interval count, 3 timebase low word |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |
| irq_pit | output | 1 | Interval timer interrupt request |
| irq_fit | output | 1 | Fixed-interval interrupt request |
| irq_wdt | output | 1 | Watchdog interrupt request |
| rst_core_req | output | 1 | One-cycle core reset request |
| rst_chip_req | output | 1 | One-cycle chip reset request |
| rst_sys_req | output | 1 | One-cycle system reset request |

## Verification
Every state change takes effect at the rising edge that samples the tick or the write. Status bits, count, timebase, interrupts and reset requests therefore all become valid in the cycle after that edge. The reset requests last for exactly that one cycle. Read data is a combinational view of the registers, so it shows the new value in the same window. The bench drives inputs on the falling edge and steps its reference model at the rising edge. It compares every output and the selected read word 2 ns after that edge, before the next stimulus is applied.

// File: rtl/emb_tmr_pkg.sv
`timescale 1ns/1ps
package emb_tmr_pkg;

   localparam int DATA_W = 32;

   // register select codes shared by the write and read ports
   typedef enum logic [1:0] {
      SEL_CTL = 2'd0,
      SEL_STS = 2'd1,
      SEL_PIT = 2'd2,
      SEL_TB  = 2'd3
   } reg_sel_e;

   // control field positions (low bit of multi-bit fields)
   localparam int C_WDT_PER = 30;
   localparam int C_WDT_RST = 28;
   localparam int C_WDT_IE  = 27;
   localparam int C_PIT_EN  = 26;
   localparam int C_FIT_PER = 24;
   localparam int C_FIT_IE  = 23;
   localparam int C_PIT_AR  = 22;

   // status field positions
   localparam int S_WDT_TOP = 31;
   localparam int S_PIT     = 27;
   localparam int S_FIT     = 26;

   localparam logic [DATA_W-1:0] CTL_KEEP = 32'hFFC0_0000;
   localparam logic [DATA_W-1:0] STS_W1C  = 32'hFC00_0000;

   typedef enum logic [1:0] {
      WRST_NONE = 2'd0,
      WRST_CORE = 2'd1,
      WRST_CHIP = 2'd2,
      WRST_SYS  = 2'd3
   } wdt_rst_e;

endpackage

// File: rtl/emb_tmr_timebase.sv
`timescale 1ns/1ps
module emb_tmr_timebase #(
   parameter int TB_W      = 32,
   parameter int FIT_BASE  = 9,
   parameter int WDT_BASE  = 17,
   parameter int TAP_STEP  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [1:0]      fit_sel,
   input  logic [1:0]      wdt_sel,
   output logic [TB_W-1:0] tb_q,
   output logic            fit_fire,
   output logic            wdt_fire
);

   localparam int NTAP  = 2;
   localparam int IDX_W = $clog2(TB_W);
   localparam logic [TB_W-1:0] ONE = TB_W'(1);

   // elaboration-time parameter checks
   if (FIT_BASE < 1 || WDT_BASE < 1) begin : g_bad_base
      $error("emb_tmr_timebase: tap bases must be at least 1");
   end
   if (TAP_STEP < 1) begin : g_bad_step
      $error("emb_tmr_timebase: TAP_STEP must be at least 1");
   end
   if (FIT_BASE + 3*TAP_STEP >= TB_W || WDT_BASE + 3*TAP_STEP >= TB_W) begin : g_bad_width
      $error("emb_tmr_timebase: highest tap exceeds timebase width");
   end

   logic [TB_W-1:0] tb_nxt;
   logic [NTAP-1:0] fire;

   assign tb_nxt = tb_q + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tb_q <= '0;
      else if (tick)
         tb_q <= tb_nxt;
   end

   // one rising-bit detector per tapped timer
   for (genvar g = 0; g < NTAP; g++) begin : g_tap
      localparam int BASE = (g == 0) ? FIT_BASE : WDT_BASE;
      logic [1:0]       sel;
      logic [IDX_W-1:0] idx;
      assign sel  = (g == 0) ? fit_sel : wdt_sel;
      assign idx  = IDX_W'(BASE + TAP_STEP * int'(sel));
      assign fire[g] = tick & ~tb_q[idx] & tb_nxt[idx];
   end

   assign fit_fire = fire[0];
   assign wdt_fire = fire[1];

endmodule

// File: rtl/emb_tmr_pit.sv
`timescale 1ns/1ps
module emb_tmr_pit #(
   parameter int PIT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [PIT_W-1:0] load_val,
   input  logic             run_en,
   input  logic             auto_rl,
   output logic [PIT_W-1:0] count,
   output logic             running,
   output logic             expire
);

   localparam logic [PIT_W-1:0] ONE = PIT_W'(1);

   if (PIT_W < 2) begin : g_bad_w
      $error("emb_tmr_pit: PIT_W must be at least 2");
   end

   logic [PIT_W-1:0] rel_q;
   logic [PIT_W-1:0] cnt_q;
   logic             armed_q;

   assign running = armed_q & run_en & (rel_q > ONE);
   assign expire  = tick & running & (cnt_q <= ONE) & ~load;
   assign count   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q   <= '0;
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load) begin
         rel_q   <= load_val;
         cnt_q   <= load_val;
         armed_q <= 1'b1;
      end else if (expire) begin
         if (auto_rl) begin
            cnt_q <= rel_q;
         end else begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end
      end else if (tick && running) begin
         cnt_q <= cnt_q - ONE;
      end
   end

endmodule

// File: rtl/emb_tmr_wdt.sv
`timescale 1ns/1ps
module emb_tmr_wdt
   import emb_tmr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fire,
   input  logic [1:0] rst_kind,
   input  logic [3:0] clr,
   output logic [3:0] stat,
   output logic       rst_core,
   output logic       rst_chip,
   output logic       rst_sys
);

   localparam int NKIND = 3;

   logic       armed_q;
   logic       irq_q;
   logic [1:0] last_q;
   logic       final_stage;
   logic [NKIND-1:0] req_q;

   assign final_stage = fire & armed_q & irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         irq_q   <= 1'b0;
         last_q  <= 2'b00;
      end else begin
         armed_q <= (armed_q & ~clr[3]) | (fire & ~armed_q);
         irq_q   <= (irq_q & ~clr[2]) | (fire & armed_q & ~irq_q);
         if (final_stage)
            last_q <= rst_kind;
         else
            last_q <= last_q & ~clr[1:0];
      end
   end

   // one registered request per non-zero reset kind
   for (genvar k = 0; k < NKIND; k++) begin : g_req
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            req_q[k] <= 1'b0;
         else
            req_q[k] <= final_stage && (rst_kind == 2'(k + 1));
      end
   end

   assign stat     = {armed_q, irq_q, last_q};
   assign rst_core = req_q[int'(WRST_CORE) - 1];
   assign rst_chip = req_q[int'(WRST_CHIP) - 1];
   assign rst_sys  = req_q[int'(WRST_SYS) - 1];

endmodule

// File: rtl/emb_tmr_unit.sv
`timescale 1ns/1ps
module emb_tmr_unit
   import emb_tmr_pkg::*;
#(
   parameter int TB_W     = 32,
   parameter int PIT_W    = 32,
   parameter int FIT_BASE = 9,
   parameter int WDT_BASE = 17,
   parameter int TAP_STEP = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tb_tick,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [31:0] wr_data,
   input  logic [1:0]  rd_sel,
   output logic [31:0] rd_data,
   output logic        irq_pit,
   output logic        irq_fit,
   output logic        irq_wdt,
   output logic        rst_core_req,
   output logic        rst_chip_req,
   output logic        rst_sys_req
);

   if (PIT_W > DATA_W) begin : g_bad_pit
      $error("emb_tmr_unit: PIT_W must not exceed the data width");
   end
   if (TB_W < DATA_W) begin : g_bad_tb
      $error("emb_tmr_unit: TB_W must be at least the data width");
   end

   logic              wr_ctl, wr_sts, wr_rel;
   logic [DATA_W-1:0] ctl_q;
   logic [DATA_W-1:0] clr_v;
   logic [DATA_W-1:0] sts_v;
   logic              fit_sts_q, pit_sts_q;
   logic [TB_W-1:0]   tb_q;
   logic              fit_fire, wdt_fire;
   logic [PIT_W-1:0]  pit_cnt;
   logic              pit_run, pit_expire;
   logic [3:0]        wdt_stat;
   logic [DATA_W-1:0] tb_rd, pit_rd;

   assign wr_ctl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);
   assign wr_sts = wr_en && (reg_sel_e'(wr_sel) == SEL_STS);
   assign wr_rel = wr_en && (reg_sel_e'(wr_sel) == SEL_PIT);
   assign clr_v  = wr_sts ? (wr_data & STS_W1C) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr_ctl)
         ctl_q <= wr_data & CTL_KEEP;
   end

   // event flags: a same-edge hardware set wins over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fit_sts_q <= 1'b0;
         pit_sts_q <= 1'b0;
      end else begin
         fit_sts_q <= (fit_sts_q & ~clr_v[S_FIT]) | fit_fire;
         pit_sts_q <= (pit_sts_q & ~clr_v[S_PIT]) | pit_expire;
      end
   end

   emb_tmr_timebase #(
      .TB_W     (TB_W),
      .FIT_BASE (FIT_BASE),
      .WDT_BASE (WDT_BASE),
      .TAP_STEP (TAP_STEP)
   ) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tb_tick),
      .fit_sel  (ctl_q[C_FIT_PER +: 2]),
      .wdt_sel  (ctl_q[C_WDT_PER +: 2]),
      .tb_q     (tb_q),
      .fit_fire (fit_fire),
      .wdt_fire (wdt_fire)
   );

   emb_tmr_pit #(
      .PIT_W (PIT_W)
   ) u_pit (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tb_tick),
      .load     (wr_rel),
      .load_val (wr_data[PIT_W-1:0]),
      .run_en   (ctl_q[C_PIT_EN]),
      .auto_rl  (ctl_q[C_PIT_AR]),
      .count    (pit_cnt),
      .running  (pit_run),
      .expire   (pit_expire)
   );

   emb_tmr_wdt u_wdt (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (wdt_fire),
      .rst_kind (ctl_q[C_WDT_RST +: 2]),
      .clr      (clr_v[S_WDT_TOP -: 4]),
      .stat     (wdt_stat),
      .rst_core (rst_core_req),
      .rst_chip (rst_chip_req),
      .rst_sys  (rst_sys_req)
   );

   assign sts_v = {wdt_stat, pit_sts_q, fit_sts_q, 26'd0};

   // read-back widening chosen by parameters
   if (TB_W > DATA_W) begin : g_tb_cut
      assign tb_rd = tb_q[DATA_W-1:0];
   end else begin : g_tb_full
      assign tb_rd = tb_q;
   end

   if (PIT_W < DATA_W) begin : g_pit_pad
      assign pit_rd = {{(DATA_W-PIT_W){1'b0}}, pit_cnt};
   end else begin : g_pit_full
      assign pit_rd = pit_cnt;
   end

   always_comb begin
      case (reg_sel_e'(rd_sel))
         SEL_CTL: rd_data = ctl_q;
         SEL_STS: rd_data = sts_v;
         SEL_PIT: rd_data = pit_rd;
         default: rd_data = tb_rd;
      endcase
   end

   assign irq_fit = fit_sts_q & ctl_q[C_FIT_IE];
   assign irq_pit = pit_sts_q & ctl_q[C_PIT_EN];
   assign irq_wdt = wdt_stat[2] & ctl_q[C_WDT_IE];

endmodule

// File: rtl/emb_tmr_unit_chk.sv
`timescale 1ns/1ps
module emb_tmr_unit_chk #(
   parameter int TB_W  = 32,
   parameter int PIT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tb_tick,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [31:0]      wr_data,
   input logic [31:0]      ctl_q,
   input logic [31:0]      sts_v,
   input logic [TB_W-1:0]  tb_q,
   input logic [PIT_W-1:0] pit_cnt,
   input logic             pit_run,
   input logic             rst_core_req,
   input logic             rst_chip_req,
   input logic             rst_sys_req
);

   logic [2:0] rst_v;
   assign rst_v = {rst_sys_req, rst_chip_req, rst_core_req};

   p_ctl_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> (ctl_q == ($past(wr_data) & 32'hFFC0_0000)));

   p_sts_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && !tb_tick) |=> ((sts_v & $past(wr_data & 32'hFC00_0000)) == 32'd0));

   p_fit_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_v[26]) |-> $past(tb_tick));

   p_pit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pit_run && !(wr_en && wr_sel == 2'd2)) |=> $stable(pit_cnt));

   p_wdt_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_v[30]) |-> $past(sts_v[31]));

   p_rst_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rst_v));

   p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|rst_v) |=> (rst_v == 3'b000));

   p_tb_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tb_tick |=> (tb_q == TB_W'($past(tb_q) + 1'b1)));

   p_tb_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !tb_tick |=> $stable(tb_q));

endmodule

bind emb_tmr_unit emb_tmr_unit_chk #(
   .TB_W  (TB_W),
   .PIT_W (PIT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tb_tick      (tb_tick),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .wr_data      (wr_data),
   .ctl_q        (ctl_q),
   .sts_v        (sts_v),
   .tb_q         (tb_q),
   .pit_cnt      (pit_cnt),
   .pit_run      (pit_run),
   .rst_core_req (rst_core_req),
   .rst_chip_req (rst_chip_req),
   .rst_sys_req  (rst_sys_req)
);

// File: tb/emb_tmr_unit_bench.sv
`timescale 1ns/1ps
module emb_tmr_unit_bench;

   localparam int TB_W  = 32;
   localparam int PIT_W = 16;
   localparam int FB    = 2;
   localparam int WB    = 4;
   localparam int ST    = 1;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tb_tick;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [31:0] wr_data;
   logic [1:0]  rd_sel;
   logic [31:0] rd_data;
   logic        irq_pit, irq_fit, irq_wdt;
   logic        rst_core_req, rst_chip_req, rst_sys_req;

   always #5 clk = ~clk;

   emb_tmr_unit #(
      .TB_W(TB_W), .PIT_W(PIT_W), .FIT_BASE(FB), .WDT_BASE(WB), .TAP_STEP(ST)
   ) u_emb_tmr_unit (
      .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .irq_pit(irq_pit), .irq_fit(irq_fit), .irq_wdt(irq_wdt),
      .rst_core_req(rst_core_req), .rst_chip_req(rst_chip_req),
      .rst_sys_req(rst_sys_req)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // reference model state
   logic [31:0]      m_tb, m_ctl, m_sts;
   logic [PIT_W-1:0] m_rel, m_cnt;
   bit               m_arm;
   logic [2:0]       m_rst;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic m_reset();
      m_tb = '0; m_ctl = '0; m_sts = '0; m_rel = '0; m_cnt = '0; m_arm = 0; m_rst = '0;
   endtask

   task automatic m_step(input bit tick, input bit we, input logic [1:0] sel, input logic [31:0] d);
      int fb, wb;
      logic [31:0] nx, clr, s, old;
      bit ffire, wfire, run, ld, ex;
      fb    = FB + ST * int'(m_ctl[25:24]);
      wb    = WB + ST * int'(m_ctl[31:30]);
      nx    = m_tb + 1;
      ffire = tick && !m_tb[fb] && nx[fb];
      wfire = tick && !m_tb[wb] && nx[wb];
      run   = m_arm && m_ctl[26] && (m_rel > 1);
      ld    = we && sel == 2'd2;
      ex    = tick && run && (m_cnt <= 1) && !ld;
      clr   = (we && sel == 2'd1) ? (d & 32'hFC00_0000) : 32'd0;
      old   = m_sts;
      s     = m_sts & ~clr;
      if (ffire) s[26] = 1'b1;
      if (ex)    s[27] = 1'b1;
      m_rst = 3'b000;
      if (wfire) begin
         if (!old[31]) s[31] = 1'b1;
         else if (!old[30]) s[30] = 1'b1;
         else begin
            s[29:28] = m_ctl[29:28];
            if (m_ctl[29:28] != 2'd0) m_rst[m_ctl[29:28] - 2'd1] = 1'b1;
         end
      end
      if (ld) begin
         m_rel = d[PIT_W-1:0]; m_cnt = d[PIT_W-1:0]; m_arm = 1;
      end else if (ex) begin
         if (m_ctl[22]) m_cnt = m_rel;
         else begin m_cnt = '0; m_arm = 0; end
      end else if (tick && run) begin
         m_cnt = m_cnt - 1'b1;
      end
      if (tick) m_tb = nx;
      if (we && sel == 2'd0) m_ctl = d & 32'hFFC0_0000;
      m_sts = s;
   endtask

   // one clock: drive on falling edge, step model at rising edge, compare after it
   task automatic cyc(input bit tick, input bit we, input logic [1:0] sel,
                      input logic [31:0] d, input logic [1:0] rs);
      logic [31:0] exp_rd;
      @(negedge clk);
      tb_tick = tick; wr_en = we; wr_sel = sel; wr_data = d; rd_sel = rs;
      @(posedge clk);
      m_step(tick, we, sel, d);
      #2;
      case (rs)
         2'd0: exp_rd = m_ctl;
         2'd1: exp_rd = m_sts;
         2'd2: exp_rd = {{(32-PIT_W){1'b0}}, m_cnt};
         default: exp_rd = m_tb;
      endcase
      case (rs)
         2'd0: chk("R1 control read", rd_data, exp_rd);
         2'd1: chk("R2 status read", rd_data, exp_rd);
         2'd2: chk("R4 count read", rd_data, exp_rd);
         default: chk("R12 timebase read", rd_data, exp_rd);
      endcase
      chk("R3 irq_fit", {31'd0, irq_fit}, {31'd0, m_sts[26] & m_ctl[23]});
      chk("R5 irq_pit", {31'd0, irq_pit}, {31'd0, m_sts[27] & m_ctl[26]});
      chk("R8 irq_wdt", {31'd0, irq_wdt}, {31'd0, m_sts[30] & m_ctl[27]});
      chk("R9 reset requests", {29'd0, rst_sys_req, rst_chip_req, rst_core_req}, {29'd0, m_rst});
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      bit seen_irq, seen_rst;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; tb_tick = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state
      cyc(0, 0, 2'd0, 0, 2'd0); chk("R11 control after reset", rd_data, 32'd0);
      cyc(0, 0, 2'd0, 0, 2'd1); chk("R11 status after reset", rd_data, 32'd0);
      cyc(0, 0, 2'd0, 0, 2'd2); chk("R11 count after reset", rd_data, 32'd0);
      chk("R11 outputs after reset",
          {26'd0, irq_pit, irq_fit, irq_wdt, rst_core_req, rst_chip_req, rst_sys_req}, 32'd0);

      // R1: control mask
      cyc(0, 1, 2'd0, 32'hFFFF_FFFF, 2'd0); chk("R1 masked control", rd_data, 32'hFFC0_0000);
      cyc(0, 1, 2'd0, 32'd0, 2'd0);

      // R12: write to select 3 ignored
      cyc(0, 1, 2'd3, 32'hDEAD_BEEF, 2'd3); chk("R12 timebase write ignored", rd_data, 32'd0);

      // R4 / R5 / R6: auto-reload interval timer
      cyc(0, 1, 2'd0, 32'h0440_0000, 2'd2);
      cyc(0, 1, 2'd2, 32'd5, 2'd2); chk("R4 immediate load", rd_data, 32'd5);
      repeat (4) cyc(1, 0, 2'd0, 0, 2'd2);
      chk("R4 count after 4 ticks", rd_data, 32'd1);
      cyc(1, 0, 2'd0, 0, 2'd1);
      chk("R5 expiry status", {31'd0, rd_data[27]}, 32'd1);
      chk("R5 irq_pit on expiry", {31'd0, irq_pit}, 32'd1);
      cyc(0, 0, 2'd0, 0, 2'd2); chk("R6 auto-reload value", rd_data, 32'd5);

      // R2: write-one-to-clear
      cyc(0, 1, 2'd1, 32'h0800_0000, 2'd1);
      chk("R2 cleared bit 27", {31'd0, rd_data[27]}, 32'd0);
      chk("R2 irq_pit low after clear", {31'd0, irq_pit}, 32'd0);
      cyc(0, 1, 2'd1, 32'hFFFF_FFFF, 2'd1); chk("R2 all cleared", rd_data, 32'd0);

      // R6: one-shot stop
      cyc(0, 1, 2'd0, 32'h0400_0000, 2'd2);
      cyc(0, 1, 2'd2, 32'd3, 2'd2);
      repeat (3) cyc(1, 0, 2'd0, 0, 2'd2);
      chk("R6 one-shot ends at 0", rd_data, 32'd0);
      chk("R5 irq_pit one-shot", {31'd0, irq_pit}, 32'd1);
      repeat (3) cyc(1, 0, 2'd0, 0, 2'd2);
      chk("R6 stays stopped", rd_data, 32'd0);

      // R7: hold conditions
      cyc(0, 1, 2'd1, 32'hFC00_0000, 2'd1);
      cyc(0, 1, 2'd0, 32'd0, 2'd2);
      cyc(0, 1, 2'd2, 32'd7, 2'd2);
      repeat (4) cyc(1, 0, 2'd0, 0, 2'd2);
      chk("R7 held with enable clear", rd_data, 32'd7);
      cyc(0, 1, 2'd0, 32'h0440_0000, 2'd2);
      cyc(0, 1, 2'd2, 32'd1, 2'd2);
      repeat (4) cyc(1, 0, 2'd0, 0, 2'd2);
      chk("R7 held with reload 1", rd_data, 32'd1);
      cyc(1, 0, 2'd0, 0, 2'd1);
      chk("R7 no expiry with reload 1", {31'd0, rd_data[27]}, 32'd0);

      // R10: set wins over same-edge clear
      cyc(0, 1, 2'd2, 32'd2, 2'd2);
      cyc(1, 0, 2'd0, 0, 2'd2);
      cyc(1, 1, 2'd1, 32'h0800_0000, 2'd1);
      chk("R10 set beats clear", {31'd0, rd_data[27]}, 32'd1);

      // R3: fixed interval on tap FB+ST
      cyc(0, 1, 2'd0, 32'h0180_0000, 2'd1);
      cyc(0, 1, 2'd1, 32'hFC00_0000, 2'd3);
      for (int i = 0; i < 64; i++) begin
         cyc(1, 0, 2'd0, 0, 2'd3);
         if (irq_fit) break;
      end
      chk("R3 fixed interval fired", {31'd0, irq_fit}, 32'd1);
      chk("R3 fired on tap bit rising", rd_data & 32'd15, 32'd8);

      // R8 / R9: watchdog to chip reset
      cyc(0, 1, 2'd0, 32'h2800_0000, 2'd1);
      cyc(0, 1, 2'd1, 32'hFC00_0000, 2'd1);
      seen_irq = 0; seen_rst = 0;
      for (int i = 0; i < 400; i++) begin
         cyc(1, 0, 2'd0, 0, 2'd1);
         if (irq_wdt) seen_irq = 1;
         if (rst_chip_req) begin seen_rst = 1; break; end
      end
      chk("R8 watchdog interrupt stage seen", {31'd0, seen_irq}, 32'd1);
      chk("R9 chip reset pulse", {31'd0, seen_rst}, 32'd1);
      chk("R9 reset kind recorded", {28'd0, rd_data[31:28]}, 32'hE);
      cyc(0, 0, 2'd0, 0, 2'd1);
      chk("R9 pulse lasts one cycle", {31'd0, rst_chip_req}, 32'd0);

      // constrained random phase
      for (int i = 0; i < 20000; i++) begin
         bit          t, w;
         logic [1:0]  s, r;
         logic [31:0] d;
         t = ($urandom % 4) != 0;
         w = ($urandom % 12) == 0;
         s = 2'($urandom % 4);
         r = 2'($urandom % 4);
         d = $urandom;
         if (s == 2'd2) d = $urandom % 40;
         cyc(t, w, s, d, r);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule